// File: doc/BRIEF.md
# Multi-Ring Command Stream Scheduler

This block merges command words from several circular command buffers, each owned by one host thread, into a single stream for a downstream processing pipeline. The host advances a write pointer per ring; the block keeps the matching read pointer, watches every ring's pending count without any host action, and reads one word at a time from memory over a simple request/response port. Each word leaves on a valid/ready output tagged with the context number of the ring it came from.

Among the normal rings, the block serves the one holding the most unread words, and the lowest index wins a tie. The last ring is reserved for real-time work. It is served only after an external event pulse, for example a video blanking strobe, has put the block into priority mode. In that mode it runs ahead of every normal ring until it is empty. Whenever the chosen ring differs from the context the pipeline holds, the block raises a context-switch request and waits for the acknowledge. This happens only between words. A sticky watchdog flag records any acknowledge that comes later than its budget. Normal switches and priority switches have separate budgets, 1500 and 300 cycles by default.

Top module: `cmd_ring_sched`

## Requirements
- R1: After reset, cmd_valid_o, fetch_req_o, ctx_sw_req_o and wdog_o are low, cmd_data_o and cmd_ctx_o are zero, and every read pointer on ring_rptr_o is zero.
- R2: Ring r holds 2^L words, where L is the value on its slice of ring_lgsz_i. Each word of ring r is read from address base_r + rptr_r. After each fetched word, rptr_r becomes (rptr_r + 1) mod 2^L, so the pointer wraps.
- R3: The pending count of ring r is (wptr_r - rptr_r) mod 2^L. Among the normal rings 0..NUM_RINGS-2, the ring with the largest count is served next, and the lowest index wins a tie. A ring with a count of zero is never served, and no fetch starts while every eligible ring is empty.
- R4: When the ring to serve differs from the current context, or no context has been loaded since reset, ctx_sw_req_o rises with ctx_sw_id_o set to that ring. Both hold until ctx_sw_ack_i arrives. No fetch runs during the switch. Consecutive words from the same ring cause no switch.
- R5: cmd_data_o carries the fetched word unchanged and cmd_ctx_o carries its ring index. While cmd_ready_i is low, cmd_valid_o, cmd_data_o and cmd_ctx_o hold.
- R6: A context switch starts only at a word boundary. ctx_sw_req_o is never high while an output word is pending.
- R7: A one-cycle pulse on rt_event_i enters priority mode. At the next word boundary the last ring (index NUM_RINGS-1) is served ahead of every normal ring for as long as it holds words. Once it is found empty, busiest-ring selection resumes. Outside priority mode the last ring is never served.
- R8: wdog_o goes high if ctx_sw_ack_i has not arrived within HP_BUDGET cycles of a request to the priority ring, or within SW_BUDGET cycles of a request to a normal ring. It stays high until reset, and the switch still completes.
- R9: At most one fetch is outstanding. fetch_req_o holds with a stable fetch_addr_o until fetch_rvalid_i, and fetch_req_o, ctx_sw_req_o and cmd_valid_o are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_base_i | input | NUM_RINGS*ADDR_W | Word base address of each ring, ring 0 in the low slice |
| ring_lgsz_i | input | NUM_RINGS*LGS_W | log2 of each ring's size in words |
| ring_wptr_i | input | NUM_RINGS*PTR_W | Host-written write pointer of each ring |
| ring_rptr_o | output | NUM_RINGS*PTR_W | Read pointer of each ring |
| rt_event_i | input | 1 | Real-time event pulse that enters priority mode |
| fetch_req_o | output | 1 | Memory read request |
| fetch_addr_o | output | ADDR_W | Memory read word address |
| fetch_rvalid_i | input | 1 | Memory read data valid |
| fetch_rdata_i | input | DATA_W | Memory read data |
| ctx_sw_req_o | output | 1 | Context-switch request to the pipeline |
| ctx_sw_id_o | output | CTX_W | Context requested by the switch |
| ctx_sw_ack_i | input | 1 | Context-switch acknowledge |
| cmd_valid_o | output | 1 | Output word valid |
| cmd_ready_i | input | 1 | Output word accepted |
| cmd_data_o | output | DATA_W | Output command word |
| cmd_ctx_o | output | CTX_W | Context of the output word |
| wdog_o | output | 1 | Sticky late-acknowledge flag |

## Verification
The properties assume the following about the environment. Memory answers only while a request is open, the pipeline acknowledges only while a switch is open, and ring bases stay fixed while a fetch is pending. The host also never fills a ring completely, never moves a write pointer backwards, and keeps each log2 size within PTR_W and unchanged while its ring holds words. The bench's memory and acknowledge models respond only to an open request. The stimulus sets bases and sizes once. It moves write pointers only forward by fewer words than the ring size, and it clears them to zero before each reset, so that no stale occupancy appears afterwards.

// File: rtl/cmd_sched_pkg.sv
package cmd_sched_pkg;

   typedef enum logic [1:0] {
      ST_PICK   = 2'd0,
      ST_SWITCH = 2'd1,
      ST_FETCH  = 2'd2,
      ST_OUT    = 2'd3
   } sched_st_e;

endpackage

// File: rtl/cmd_ring_ptrs.sv
module cmd_ring_ptrs #(
   parameter int NUM_RINGS = 4,
   parameter int PTR_W     = 8,
   parameter int LGS_W     = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_RINGS*LGS_W-1:0] lgsz_i,
   input  logic [NUM_RINGS*PTR_W-1:0] wptr_i,
   input  logic [NUM_RINGS-1:0]       adv_i,
   output logic [NUM_RINGS*PTR_W-1:0] rptr_o,
   output logic [NUM_RINGS*PTR_W-1:0] occ_o
);

   for (genvar r = 0; r < NUM_RINGS; r++) begin : g_ring
      logic [PTR_W:0]   span;
      logic [PTR_W-1:0] mask;
      logic [PTR_W-1:0] rp_q;
      logic [PTR_W-1:0] wp;

      assign span = {{PTR_W{1'b0}}, 1'b1} << lgsz_i[r*LGS_W +: LGS_W];
      assign mask = PTR_W'(span - 1'b1);
      assign wp   = wptr_i[r*PTR_W +: PTR_W];

      always_ff @(posedge clk) begin
         if (!rst_n)
            rp_q <= '0;
         else if (adv_i[r])
            rp_q <= (rp_q + 1'b1) & mask;
      end

      assign rptr_o[r*PTR_W +: PTR_W] = rp_q;
      assign occ_o[r*PTR_W +: PTR_W]  = (wp - rp_q) & mask;
   end

endmodule

// File: rtl/cmd_ring_pick.sv
module cmd_ring_pick #(
   parameter int NUM_CAND = 3,
   parameter int PTR_W    = 8,
   parameter int IDX_W    = 2
) (
   input  logic [NUM_CAND*PTR_W-1:0] occ_i,
   output logic                      any_o,
   output logic [IDX_W-1:0]          idx_o
);

   logic [PTR_W-1:0] best;

   always_comb begin
      best  = '0;
      idx_o = '0;
      for (int i = 0; i < NUM_CAND; i++) begin
         if (occ_i[i*PTR_W +: PTR_W] > best) begin
            best  = occ_i[i*PTR_W +: PTR_W];
            idx_o = IDX_W'(i);
         end
      end
   end

   assign any_o = (best != '0);

endmodule

// File: rtl/cmd_sw_timer.sv
module cmd_sw_timer #(
   parameter int SW_BUDGET = 1500,
   parameter int HP_BUDGET = 300
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   input  logic hp_i,
   output logic late_o
);

   localparam int MAXB = (SW_BUDGET > HP_BUDGET) ? SW_BUDGET : HP_BUDGET;
   localparam int CW   = $clog2(MAXB + 1);

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] lim_m1;

   assign lim_m1 = hp_i ? CW'(HP_BUDGET - 1) : CW'(SW_BUDGET - 1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         late_o <= 1'b0;
      end else begin
         if (!run_i)
            cnt_q <= '0;
         else if (cnt_q != CW'(MAXB))
            cnt_q <= cnt_q + 1'b1;
         if (run_i && (cnt_q == lim_m1))
            late_o <= 1'b1;
      end
   end

endmodule

// File: rtl/cmd_ring_sched.sv
module cmd_ring_sched
   import cmd_sched_pkg::*;
#(
   parameter int NUM_RINGS = 4,
   parameter int ADDR_W    = 32,
   parameter int DATA_W    = 32,
   parameter int PTR_W     = 8,
   parameter int SW_BUDGET = 1500,
   parameter int HP_BUDGET = 300,
   localparam int LGS_W    = $clog2(PTR_W + 1),
   localparam int CTX_W    = $clog2(NUM_RINGS)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_RINGS*ADDR_W-1:0] ring_base_i,
   input  logic [NUM_RINGS*LGS_W-1:0] ring_lgsz_i,
   input  logic [NUM_RINGS*PTR_W-1:0] ring_wptr_i,
   output logic [NUM_RINGS*PTR_W-1:0] ring_rptr_o,
   input  logic                       rt_event_i,
   output logic                       fetch_req_o,
   output logic [ADDR_W-1:0]          fetch_addr_o,
   input  logic                       fetch_rvalid_i,
   input  logic [DATA_W-1:0]          fetch_rdata_i,
   output logic                       ctx_sw_req_o,
   output logic [CTX_W-1:0]           ctx_sw_id_o,
   input  logic                       ctx_sw_ack_i,
   output logic                       cmd_valid_o,
   input  logic                       cmd_ready_i,
   output logic [DATA_W-1:0]          cmd_data_o,
   output logic [CTX_W-1:0]           cmd_ctx_o,
   output logic                       wdog_o
);

   localparam int HP_ID = NUM_RINGS - 1;
   localparam int NORM  = NUM_RINGS - 1;

   if (NUM_RINGS < 2) begin : g_chk_rings
      $error("cmd_ring_sched: NUM_RINGS must be at least 2");
   end
   if (PTR_W > ADDR_W) begin : g_chk_ptr
      $error("cmd_ring_sched: PTR_W must not exceed ADDR_W");
   end
   if (HP_BUDGET < 1 || SW_BUDGET < 1) begin : g_chk_budget
      $error("cmd_ring_sched: switch budgets must be positive");
   end

   sched_st_e              state_q;
   logic [CTX_W-1:0]       cur_q;
   logic [CTX_W-1:0]       tgt_q;
   logic                   ctx_ok_q;
   logic                   hp_mode_q;
   logic [DATA_W-1:0]      data_q;
   logic [CTX_W-1:0]       tag_q;

   logic [NUM_RINGS*PTR_W-1:0] rptr_all;
   logic [NUM_RINGS*PTR_W-1:0] occ_all;
   logic [NUM_RINGS-1:0]       adv;
   logic [CTX_W-1:0]           pick_idx;
   logic [CTX_W-1:0]           nxt_tgt;
   logic                       pick_any;
   logic                       hp_pend;
   logic                       have_work;
   logic [PTR_W-1:0]           hp_occ;
   logic [PTR_W-1:0]           tgt_rptr;
   logic                       late;

   cmd_ring_ptrs #(
      .NUM_RINGS (NUM_RINGS),
      .PTR_W     (PTR_W),
      .LGS_W     (LGS_W)
   ) u_ptrs (
      .clk    (clk),
      .rst_n  (rst_n),
      .lgsz_i (ring_lgsz_i),
      .wptr_i (ring_wptr_i),
      .adv_i  (adv),
      .rptr_o (rptr_all),
      .occ_o  (occ_all)
   );

   cmd_ring_pick #(
      .NUM_CAND (NORM),
      .PTR_W    (PTR_W),
      .IDX_W    (CTX_W)
   ) u_pick (
      .occ_i (occ_all[NORM*PTR_W-1:0]),
      .any_o (pick_any),
      .idx_o (pick_idx)
   );

   cmd_sw_timer #(
      .SW_BUDGET (SW_BUDGET),
      .HP_BUDGET (HP_BUDGET)
   ) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  ((state_q == ST_SWITCH) && !ctx_sw_ack_i),
      .hp_i   (tgt_q == CTX_W'(HP_ID)),
      .late_o (late)
   );

   assign hp_occ    = occ_all[HP_ID*PTR_W +: PTR_W];
   assign hp_pend   = hp_mode_q && (hp_occ != '0);
   assign nxt_tgt   = hp_pend ? CTX_W'(HP_ID) : pick_idx;
   assign have_work = hp_pend || pick_any;
   assign tgt_rptr  = rptr_all[int'(tgt_q)*PTR_W +: PTR_W];

   always_comb begin
      adv = '0;
      if (state_q == ST_FETCH && fetch_rvalid_i)
         adv[tgt_q] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= ST_PICK;
         cur_q    <= '0;
         tgt_q    <= '0;
         ctx_ok_q <= 1'b0;
         data_q   <= '0;
         tag_q    <= '0;
      end else begin
         case (state_q)
            ST_PICK: begin
               if (have_work) begin
                  tgt_q <= nxt_tgt;
                  if (ctx_ok_q && (cur_q == nxt_tgt))
                     state_q <= ST_FETCH;
                  else
                     state_q <= ST_SWITCH;
               end
            end
            ST_SWITCH: begin
               if (ctx_sw_ack_i) begin
                  cur_q    <= tgt_q;
                  ctx_ok_q <= 1'b1;
                  state_q  <= ST_FETCH;
               end
            end
            ST_FETCH: begin
               if (fetch_rvalid_i) begin
                  data_q  <= fetch_rdata_i;
                  tag_q   <= tgt_q;
                  state_q <= ST_OUT;
               end
            end
            default: begin
               if (cmd_ready_i)
                  state_q <= ST_PICK;
            end
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         hp_mode_q <= 1'b0;
      else if (rt_event_i)
         hp_mode_q <= 1'b1;
      else if (state_q == ST_PICK && hp_occ == '0)
         hp_mode_q <= 1'b0;
   end

   assign ring_rptr_o  = rptr_all;
   assign fetch_req_o  = (state_q == ST_FETCH);
   assign fetch_addr_o = ring_base_i[int'(tgt_q)*ADDR_W +: ADDR_W] + ADDR_W'(tgt_rptr);
   assign ctx_sw_req_o = (state_q == ST_SWITCH);
   assign ctx_sw_id_o  = tgt_q;
   assign cmd_valid_o  = (state_q == ST_OUT);
   assign cmd_data_o   = data_q;
   assign cmd_ctx_o    = tag_q;
   assign wdog_o       = late;

endmodule

// File: rtl/cmd_ring_sched_chk.sv
module cmd_ring_sched_chk #(
   parameter int NUM_RINGS = 4,
   parameter int ADDR_W    = 32,
   parameter int DATA_W    = 32,
   parameter int CTX_W     = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_valid_o,
   input logic              cmd_ready_i,
   input logic [DATA_W-1:0] cmd_data_o,
   input logic [CTX_W-1:0]  cmd_ctx_o,
   input logic              ctx_sw_req_o,
   input logic              ctx_sw_ack_i,
   input logic [CTX_W-1:0]  ctx_sw_id_o,
   input logic              fetch_req_o,
   input logic              fetch_rvalid_i,
   input logic [ADDR_W-1:0] fetch_addr_o,
   input logic              wdog_o
);

   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_data_o) && $stable(cmd_ctx_o)); // R5
   AST_CTX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid_o |-> (int'(cmd_ctx_o) < NUM_RINGS)); // R5
   AST_SW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ctx_sw_req_o && !ctx_sw_ack_i |=> ctx_sw_req_o && $stable(ctx_sw_id_o)); // R4
   AST_NO_FETCH_IN_SW: assert property (@(posedge clk) disable iff (!rst_n)
      !(ctx_sw_req_o && fetch_req_o)); // R4
   AST_WORD_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
      !(ctx_sw_req_o && cmd_valid_o)); // R6
   AST_FETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_req_o && !fetch_rvalid_i |=> fetch_req_o && $stable(fetch_addr_o)); // R9
   AST_ONE_ACTIVITY: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({fetch_req_o, ctx_sw_req_o, cmd_valid_o})); // R9
   AST_WDOG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      wdog_o |=> wdog_o); // R8

endmodule

bind cmd_ring_sched cmd_ring_sched_chk #(
   .NUM_RINGS (NUM_RINGS),
   .ADDR_W    (ADDR_W),
   .DATA_W    (DATA_W),
   .CTX_W     (CTX_W)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .cmd_valid_o    (cmd_valid_o),
   .cmd_ready_i    (cmd_ready_i),
   .cmd_data_o     (cmd_data_o),
   .cmd_ctx_o      (cmd_ctx_o),
   .ctx_sw_req_o   (ctx_sw_req_o),
   .ctx_sw_ack_i   (ctx_sw_ack_i),
   .ctx_sw_id_o    (ctx_sw_id_o),
   .fetch_req_o    (fetch_req_o),
   .fetch_rvalid_i (fetch_rvalid_i),
   .fetch_addr_o   (fetch_addr_o),
   .wdog_o         (wdog_o)
);

// File: tb/cmd_ring_sched_tb.sv
module cmd_ring_sched_tb;

   localparam int NR    = 4;
   localparam int AW    = 32;
   localparam int DW    = 32;
   localparam int PW    = 8;
   localparam int LW    = $clog2(PW + 1);
   localparam int CW    = $clog2(NR);
   localparam int SWB   = 40;
   localparam int HPB   = 8;
   localparam logic [31:0] XKEY = 32'hC0DE0000;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [NR*AW-1:0] base_v;
   logic [NR*LW-1:0] lgsz_v;
   logic [NR*PW-1:0] wptr_v = '0;
   logic [NR*PW-1:0] rptr_w;
   logic             rt_event = 1'b0;
   logic             fetch_req;
   logic [AW-1:0]    fetch_addr;
   logic             fetch_rvalid = 1'b0;
   logic [DW-1:0]    fetch_rdata = '0;
   logic             sw_req;
   logic [CW-1:0]    sw_id;
   logic             sw_ack = 1'b0;
   logic             cmd_valid;
   logic             cmd_ready = 1'b1;
   logic [DW-1:0]    cmd_data;
   logic [CW-1:0]    cmd_ctx;
   logic             wdog;

   cmd_ring_sched #(
      .NUM_RINGS (NR), .ADDR_W (AW), .DATA_W (DW), .PTR_W (PW),
      .SW_BUDGET (SWB), .HP_BUDGET (HPB)
   ) u_dut (
      .clk (clk), .rst_n (rst_n),
      .ring_base_i (base_v), .ring_lgsz_i (lgsz_v),
      .ring_wptr_i (wptr_v), .ring_rptr_o (rptr_w),
      .rt_event_i (rt_event),
      .fetch_req_o (fetch_req), .fetch_addr_o (fetch_addr),
      .fetch_rvalid_i (fetch_rvalid), .fetch_rdata_i (fetch_rdata),
      .ctx_sw_req_o (sw_req), .ctx_sw_id_o (sw_id), .ctx_sw_ack_i (sw_ack),
      .cmd_valid_o (cmd_valid), .cmd_ready_i (cmd_ready),
      .cmd_data_o (cmd_data), .cmd_ctx_o (cmd_ctx),
      .wdog_o (wdog)
   );

   always #5 clk = ~clk;

   int n_chk = 0;
   int n_fail = 0;
   int base_a [NR] = '{32'h0100, 32'h1000, 32'h3000, 32'h8000};
   int lg_a   [NR] = '{2, 3, 3, 3};
   int mrptr  [NR] = '{0, 0, 0, 0};
   int last_ctx = -1;
   int ack_dly = 2;
   logic [DW-1:0] got_data [64];
   int            got_ctx  [64];
   int            n_got = 0;
   int            sw_ids   [64];
   int            n_sw = 0;

   initial begin
      for (int r = 0; r < NR; r++) begin
         base_v[r*AW +: AW] = AW'(base_a[r]);
         lgsz_v[r*LW +: LW] = LW'(lg_a[r]);
      end
   end

   // memory model: answers any open request one sample later
   initial forever begin
      @(negedge clk);
      fetch_rvalid = fetch_req;
      fetch_rdata  = fetch_addr ^ XKEY;
   end

   // pipeline model: acknowledges after ack_dly cycles of request
   initial begin
      int cnt = 0;
      forever begin
         @(negedge clk);
         if (sw_req) cnt++; else cnt = 0;
         sw_ack = sw_req && (cnt > ack_dly);
         if (sw_req && sw_ack && n_sw < 64) begin
            sw_ids[n_sw] = int'(sw_id);
            n_sw++;
         end
      end
   end

   // output monitor
   initial forever begin
      @(negedge clk);
      if (cmd_valid && cmd_ready && n_got < 64) begin
         got_data[n_got] = cmd_data;
         got_ctx[n_got]  = int'(cmd_ctx);
         n_got++;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic clear_log();
      @(posedge clk); #1;
      n_got = 0;
      n_sw  = 0;
   endtask

   task automatic push(input int r, input int n);
      wptr_v[r*PW +: PW] = PW'((int'(rptr_w[r*PW +: PW]) + n) % (1 << lg_a[r]));
   endtask

   task automatic wait_words(input int n);
      int t = 0;
      while (n_got < n && t < 3000) begin
         @(posedge clk);
         t++;
      end
      repeat (20) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk_word(input int k, input int ring, input string req);
      logic [DW-1:0] exp;
      exp = DW'(base_a[ring] + mrptr[ring]) ^ XKEY;
      chk(got_ctx[k] == ring, req, $sformatf("word %0d ctx", k), got_ctx[k], ring);
      chk(got_data[k] == exp, "R2", $sformatf("word %0d data", k), got_data[k], exp);
      mrptr[ring] = (mrptr[ring] + 1) % (1 << lg_a[ring]);
      last_ctx = ring;
   endtask

   task automatic do_reset();
      @(posedge clk); #1;
      wptr_v = '0;
      rst_n  = 1'b0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      for (int r = 0; r < NR; r++) mrptr[r] = 0;
      last_ctx = -1;
   endtask

   task automatic t_reset();
      do_reset();
      @(negedge clk);
      chk(!cmd_valid && !fetch_req && !sw_req, "R1", "idle outputs",
          {cmd_valid, fetch_req, sw_req}, 0);
      chk(wdog == 1'b0, "R1", "wdog", wdog, 0);
      chk(cmd_data == '0 && cmd_ctx == '0, "R1", "data/ctx", cmd_data, 0);
      chk(rptr_w == '0, "R1", "rptr", rptr_w, 0);
   endtask

   task automatic t_single();
      clear_log();
      push(1, 3);
      wait_words(3);
      chk(n_got == 3, "R3", "single-ring count", n_got, 3);
      for (int k = 0; k < 3; k++) chk_word(k, 1, "R5");
      chk(n_sw == 1 && sw_ids[0] == 1, "R4", "one switch to ring1", n_sw, 1);
      chk(int'(rptr_w[1*PW +: PW]) == 3, "R2", "rptr1", rptr_w[1*PW +: PW], 3);
      chk(!fetch_req && !cmd_valid, "R3", "idle when empty", fetch_req, 0);
   endtask

   task automatic run_busiest(input int o0, input int o1, input int o2, input string req);
      int occ [3];
      int seq [64];
      int total;
      int prev;
      int exp_sw;
      occ[0] = o0; occ[1] = o1; occ[2] = o2;
      total = o0 + o1 + o2;
      for (int k = 0; k < total; k++) begin
         int b = 0;
         for (int r = 1; r < 3; r++) if (occ[r] > occ[b]) b = r;
         seq[k] = b;
         occ[b]--;
      end
      prev = last_ctx;
      exp_sw = 0;
      for (int k = 0; k < total; k++) begin
         if (seq[k] != prev) exp_sw++;
         prev = seq[k];
      end
      clear_log();
      push(0, o0); push(1, o1); push(2, o2);
      wait_words(total);
      chk(n_got == total, req, "word count", n_got, total);
      for (int k = 0; k < total; k++) chk_word(k, seq[k], req);
      chk(n_sw == exp_sw, "R4", "switch count", n_sw, exp_sw);
   endtask

   task automatic t_ready_hold();
      logic [DW-1:0] d0;
      bit ok = 1'b1;
      clear_log();
      cmd_ready = 1'b0;
      push(2, 2);
      while (!cmd_valid) @(negedge clk);
      d0 = cmd_data;
      repeat (8) begin
         @(negedge clk);
         if (!cmd_valid || cmd_data != d0 || cmd_ctx != CW'(2)) ok = 1'b0;
      end
      chk(ok, "R5", "hold under backpressure", cmd_data, d0);
      chk(!sw_req, "R6", "no switch while word pending", sw_req, 0);
      @(posedge clk); #1 cmd_ready = 1'b1;
      wait_words(2);
      chk(n_got == 2, "R5", "held words", n_got, 2);
      for (int k = 0; k < 2; k++) chk_word(k, 2, "R5");
   endtask

   task automatic t_prio();
      clear_log();
      push(3, 2);
      repeat (30) @(posedge clk);
      @(negedge clk);
      chk(n_got == 0, "R7", "priority ring idle outside mode", n_got, 0);
      chk(rptr_w[3*PW +: PW] == '0, "R7", "rptr3 untouched", rptr_w[3*PW +: PW], 0);
      @(posedge clk); #1;
      cmd_ready = 1'b0;
      push(0, 3);
      while (!cmd_valid) @(negedge clk);
      @(posedge clk); #1 rt_event = 1'b1;
      @(posedge clk); #1 rt_event = 1'b0;
      cmd_ready = 1'b1;
      wait_words(5);
      chk(n_got == 5, "R7", "word count", n_got, 5);
      chk_word(0, 0, "R7");
      chk_word(1, 3, "R7");
      chk_word(2, 3, "R7");
      chk_word(3, 0, "R7");
      chk_word(4, 0, "R7");
      chk(n_sw == 3 && sw_ids[1] == 3 && sw_ids[2] == 0, "R7", "switch ids",
          sw_ids[1], 3);
      chk(wdog == 1'b0, "R8", "no flag within budget", wdog, 0);
   endtask

   task automatic t_wdog();
      clear_log();
      ack_dly = 20;
      push(1, 1);
      wait_words(1);
      chk_word(0, 1, "R8");
      chk(wdog == 1'b0, "R8", "normal switch at 21 of 40", wdog, 0);
      clear_log();
      ack_dly = 12;
      push(3, 1);
      repeat (2) @(posedge clk);
      #1 rt_event = 1'b1;
      @(posedge clk); #1 rt_event = 1'b0;
      wait_words(1);
      chk_word(0, 3, "R7");
      chk(wdog == 1'b1, "R8", "priority switch over 8", wdog, 1);
      t_reset();
      clear_log();
      ack_dly = 60;
      push(0, 1);
      wait_words(1);
      chk(n_got == 1, "R8", "late switch completes", n_got, 1);
      chk_word(0, 0, "R8");
      chk(wdog == 1'b1, "R8", "normal switch over 40", wdog, 1);
      ack_dly = 2;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      t_reset();
      t_single();
      run_busiest(2, 0, 4, "R3");
      run_busiest(3, 3, 0, "R3");
      t_ready_hold();
      t_prio();
      t_wdog();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule